// File: doc/BRIEF.md
# Two-Operand AND Display Unit

This block is a small board-level datapath that takes two 8-bit operands from a bank of switches and shows them on eight hex digits. Each of three push-buttons has its own job. One loads the switch value into operand A. One loads the switch value into operand B. The third stores the bitwise AND of the two operands in a result register.

The buttons are active low. Each one is synchronised to the system clock, and a one-cycle strobe is raised on every release-to-press transition. The strobe is not filtered for bounce.

Each register drives a fixed pair of active-low seven-segment digits, and two digits are held dark. A user sets the switches, presses the operand buttons, then presses the compute button and reads all three values off the display.

Top module: `and_disp_top`

## Requirements
- R1: When key 3 goes from high to low, the switch value is stored as operand A. A is then shown with its high nibble on digit 7 and its low nibble on digit 6.
- R2: When key 2 goes from high to low, the switch value is stored as operand B. B is then shown with its high nibble on digit 5 and its low nibble on digit 4.
- R3: When key 1 goes from high to low, the bitwise AND of A and B is stored as the result. The result is then shown with its high nibble on digit 1 and its low nibble on digit 0.
- R4: Digits 2 and 3 always drive all seven segment lines high (7'h7F).
- R5: Each digit bus is ordered {g,f,e,d,c,b,a}, and a 0 turns a segment on. Before inversion, the lit patterns for hex digits 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 67, 77, 7C, 39, 5E, 79 and 71.
- R6: Holding a key low loads its register once only. A change to the switches while the key stays low leaves the register unchanged.
- R7: A synchronous reset clears A, B and the result. All six value digits then show 0 (bus value 7'h40).
- R8: If keys 3 and 2 are pressed together, both operands load. A key 1 press in the same cycle uses the A and B held before that cycle.
- R9: Key 0 has no effect on any register or digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_n | input | 4 | Push-buttons, active low, asynchronous |
| sw | input | 8 | Switch value |
| seg0 | output | 7 | Digit 0, result low nibble |
| seg1 | output | 7 | Digit 1, result high nibble |
| seg2 | output | 7 | Digit 2, always blank |
| seg3 | output | 7 | Digit 3, always blank |
| seg4 | output | 7 | Digit 4, operand B low nibble |
| seg5 | output | 7 | Digit 5, operand B high nibble |
| seg6 | output | 7 | Digit 6, operand A low nibble |
| seg7 | output | 7 | Digit 7, operand A high nibble |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This lengthens the path from a key press to a register update by one cycle, so every check relies on the presses being timed correctly rather than on a fixed latency. The operand values are chosen so that all sixteen hex patterns appear on the display. The bench also covers a simultaneous three-key press whose result must come from the old operands, a key held low while the switches change, and a second reset after values have been loaded.

// File: rtl/and_disp_pkg.sv
package and_disp_pkg;
    localparam int OP_W  = 8;
    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    localparam int N_DIG = 8;
    localparam int N_KEY = 4;
    localparam int NIBS  = OP_W / NIB_W;

    // key roles (bit index inside the key vector)
    localparam int K_LD_A = 3;
    localparam int K_LD_B = 2;
    localparam int K_LD_R = 1;

    typedef logic [OP_W-1:0]  op_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        op_t a;
        op_t b;
        op_t r;
    } regs_t;

    localparam seg_t SEG_DARK = '1;

    // lit pattern {g,f,e,d,c,b,a}, returned inverted (0 = lit)
    function automatic seg_t nib_to_seg(input logic [NIB_W-1:0] n);
        seg_t lit;
        case (n)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h67;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        return ~lit;
    endfunction
endpackage

// File: rtl/key_edge.sv
module key_edge #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] key_n,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] sync;
        logic [N-1:0]             prev;
    } ke_t;

    ke_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = key_n;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[STAGES-1];
        if (rst) begin
            st_d = '1;   // released keys read high
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fall = st_q.prev & ~st_q.sync[STAGES-1];

    // R6: one strobe per press, never two cycles in a row on one key
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/op_regs.sv
module op_regs
    import and_disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  op_t              sw,
    input  logic [N_KEY-1:0] ld,
    output regs_t            regs
);
    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (ld[K_LD_A]) rg_d.a = sw;
        if (ld[K_LD_B]) rg_d.b = sw;
        if (ld[K_LD_R]) rg_d.r = rg_q.a & rg_q.b;
        if (rst)        rg_d = '0;
    end

    always_ff @(posedge clk) begin
        rg_q <= rg_d;
    end

    assign regs = rg_q;

    a_r1_load_a: assert property (@(posedge clk) disable iff (rst)
        ld[K_LD_A] |=> (rg_q.a == $past(sw)));
    a_r2_load_b: assert property (@(posedge clk) disable iff (rst)
        ld[K_LD_B] |=> (rg_q.b == $past(sw)));
    // R3 and R8: result takes the operands held before the load cycle
    a_r3_and_old: assert property (@(posedge clk) disable iff (rst)
        ld[K_LD_R] |=> (rg_q.r == ($past(rg_q.a) & $past(rg_q.b))));
    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        !ld[K_LD_A] |=> $stable(rg_q.a));
    a_r9_key0_idle: assert property (@(posedge clk) disable iff (rst)
        (ld == 4'b0001) |=> $stable(rg_q));
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (rg_q == '0));
endmodule

// File: rtl/hex_digit.sv
module hex_digit
    import and_disp_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output seg_t             seg_n
);
    assign seg_n = nib_to_seg(nib);

    // R5: every hex glyph lights at least two segments
    always_comb begin
        a_r5_min_lit: assert ($countones(~seg_n) >= 2);
    end
endmodule

// File: rtl/and_disp_top.sv
module and_disp_top
    import and_disp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_KEY-1:0] key_n,
    input  logic [OP_W-1:0]  sw,
    output logic [SEG_W-1:0] seg0,
    output logic [SEG_W-1:0] seg1,
    output logic [SEG_W-1:0] seg2,
    output logic [SEG_W-1:0] seg3,
    output logic [SEG_W-1:0] seg4,
    output logic [SEG_W-1:0] seg5,
    output logic [SEG_W-1:0] seg6,
    output logic [SEG_W-1:0] seg7
);
    localparam int R_BASE = 0;
    localparam int B_BASE = 4;
    localparam int A_BASE = 6;

    logic [N_KEY-1:0] strobe;
    regs_t            regs;
    seg_t             segs [N_DIG];

    key_edge #(.N(N_KEY), .STAGES(SYNC_STAGES)) u_keys (
        .clk   (clk),
        .rst   (rst),
        .key_n (key_n),
        .fall  (strobe)
    );

    op_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .sw   (sw),
        .ld   (strobe),
        .regs (regs)
    );

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        if (g >= A_BASE && g < A_BASE + NIBS) begin : g_a
            hex_digit u_hd (.nib(regs.a[(g-A_BASE)*NIB_W +: NIB_W]), .seg_n(segs[g]));
        end else if (g >= B_BASE && g < B_BASE + NIBS) begin : g_b
            hex_digit u_hd (.nib(regs.b[(g-B_BASE)*NIB_W +: NIB_W]), .seg_n(segs[g]));
        end else if (g >= R_BASE && g < R_BASE + NIBS) begin : g_r
            hex_digit u_hd (.nib(regs.r[(g-R_BASE)*NIB_W +: NIB_W]), .seg_n(segs[g]));
        end else begin : g_dark
            assign segs[g] = SEG_DARK;
        end
    end

    assign seg0 = segs[0];
    assign seg1 = segs[1];
    assign seg2 = segs[2];
    assign seg3 = segs[3];
    assign seg4 = segs[4];
    assign seg5 = segs[5];
    assign seg6 = segs[6];
    assign seg7 = segs[7];
endmodule

// File: tb/and_disp_top_tb.sv
module and_disp_top_tb;
    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] r;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] key_n = 4'hF;
    logic [7:0] sw = 8'h00;
    logic [6:0] seg0, seg1, seg2, seg3, seg4, seg5, seg6, seg7;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] ma, mb, mr;

    always #2.5 clk = ~clk;

    and_disp_top #(.SYNC_STAGES(3)) u_dut (
        .clk(clk), .rst(rst), .key_n(key_n), .sw(sw),
        .seg0(seg0), .seg1(seg1), .seg2(seg2), .seg3(seg3),
        .seg4(seg4), .seg5(seg5), .seg6(seg6), .seg7(seg7)
    );

    // R5: expected bus for a nibble, {g..a}, 0 = lit
    function automatic logic [6:0] glyph(input logic [3:0] n);
        logic [6:0] p;
        case (n)
            0: p = 7'h3F;  1: p = 7'h06;  2: p = 7'h5B;  3: p = 7'h4F;
            4: p = 7'h66;  5: p = 7'h6D;  6: p = 7'h7D;  7: p = 7'h07;
            8: p = 7'h7F;  9: p = 7'h67;  10: p = 7'h77; 11: p = 7'h7C;
            12: p = 7'h39; 13: p = 7'h5E; 14: p = 7'h79; default: p = 7'h71;
        endcase
        return ~p;
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [6:0] act, input logic [6:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input string req);
        exp_t e;
        e.a = ma; e.b = mb; e.r = mr; e.req = req;
        exp_q.push_back(e);
        ticks(1);
    endtask

    // press the keys in mask together, hold, release; update model
    task automatic press(input logic [3:0] mask, input logic [7:0] v, input string req);
        logic [7:0] old_a, old_b;
        old_a = ma; old_b = mb;
        @(negedge clk);
        sw = v;
        key_n = ~mask;
        if (mask[3]) ma = v;
        if (mask[2]) mb = v;
        if (mask[1]) mr = old_a & old_b;
        ticks(6);
        key_n = 4'hF;
        ticks(6);
        push(req);
    endtask

    // monitor: pop expected items and compare every digit
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.req, "seg7 A hi", seg7, glyph(e.a[7:4]));
                cmp(e.req, "seg6 A lo", seg6, glyph(e.a[3:0]));
                cmp(e.req, "seg5 B hi", seg5, glyph(e.b[7:4]));
                cmp(e.req, "seg4 B lo", seg4, glyph(e.b[3:0]));
                cmp(e.req, "seg1 R hi", seg1, glyph(e.r[7:4]));
                cmp(e.req, "seg0 R lo", seg0, glyph(e.r[3:0]));
                cmp({e.req, "/R4"}, "seg3 dark", seg3, 7'h7F);
                cmp({e.req, "/R4"}, "seg2 dark", seg2, 7'h7F);
            end
        end
    end

    initial begin
        ma = '0; mb = '0; mr = '0;
        ticks(4);
        rst = 1'b0;
        ticks(2);
        push("R7 reset");
        press(4'b1000, 8'hA5, "R1 load A");
        press(4'b0100, 8'h3C, "R2 load B");
        press(4'b0010, 8'h00, "R3 and");
        press(4'b1000, 8'h01, "R5 glyphs 0 1");
        press(4'b0100, 8'h23, "R5 glyphs 2 3");
        press(4'b1000, 8'h45, "R5 glyphs 4 5");
        press(4'b0100, 8'h67, "R5 glyphs 6 7");
        press(4'b1000, 8'h89, "R5 glyphs 8 9");
        press(4'b0100, 8'hAB, "R5 glyphs A B");
        press(4'b1000, 8'hCD, "R5 glyphs C D");
        press(4'b0100, 8'hEF, "R5 glyphs E F");
        press(4'b0010, 8'h00, "R3 and CD EF");
        // R6: hold key 3, change switches while held
        @(negedge clk);
        sw = 8'h12; key_n = 4'b0111; ma = 8'h12;
        ticks(6);
        sw = 8'hFF;
        ticks(6);
        push("R6 held key");
        key_n = 4'hF;
        ticks(6);
        push("R6 after release");
        press(4'b0001, 8'h77, "R9 key0 ignored");
        press(4'b0100, 8'h3E, "R2 load B again");
        press(4'b1110, 8'hAA, "R8 simultaneous");
        press(4'b0010, 8'h00, "R8 and new operands");
        @(negedge clk);
        rst = 1'b1;
        ticks(2);
        rst = 1'b0;
        ma = '0; mb = '0; mr = '0;
        ticks(1);
        push("R7 second reset");
        while (exp_q.size() > 0) ticks(1);
        ticks(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        ticks(20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule